// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus and a B bus. Each direction has its own capture register. The A-to-B register takes the A bus value on a rising edge of its own capture clock, and the B-to-A register does the same with the B bus. A per-direction select chooses what the opposite bus receives: the live value from the other side, or that direction's stored word. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low. The register load, the select and the enable are independent of each other. Together they give isolation, one-way live or stored transfer, stores from either bus, loop-back stores and a simultaneous two-way exchange of stored words.

The data path is split into `NUM_HALVES` independent slices of `HALF_W` bits. With the defaults, that is two 8-bit halves. Each half has its own two capture clocks, two selects and two enables. The three-state pins are split into a data-out vector and a drive-enable bit per half and per bus. The data-in vector is the resolved external bus. When a bus is not driven, its data-out vector is zero.

Inside each half, the two enables are decoded every cycle into one of four transfer modes:

| Mode | Enables | Buses driven |
|---|---|---|
| MODE_ISOLATE | A-to-B enable low, B-to-A enable high | neither bus |
| MODE_DRIVE_B | A-to-B enable high, B-to-A enable high | B bus only |
| MODE_DRIVE_A | A-to-B enable low, B-to-A enable low | A bus only |
| MODE_DRIVE_BOTH | A-to-B enable high, B-to-A enable low | both buses |

Any mode can change to any other as soon as the enables change. There is no sequencing between modes. An active-low asynchronous reset clears both registers in every half.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, and after it rises with no capture edge since, every capture register holds zero. A direction that is enabled with its select high therefore drives all zeros.
- R2: A rising edge of `ab_clk[h]` loads half h of `a_in` into that half's A-to-B register. A rising edge of `ba_clk[h]` loads half h of `b_in` into that half's B-to-A register.
- R3: A register loads on its capture edge whatever the levels of the selects and enables, including while the half is isolated.
- R4: Select low (0) passes live data: `b_out` half h equals `a_in` half h, and `a_out` half h equals `b_in` half h. Select high (1) passes the stored word of that direction.
- R5: `b_drv[h]` equals `ab_oe[h]`, and `a_drv[h]` equals the inverse of `ba_oe_n[h]`. Whenever a drive bit is 0, the matching data-out half is all zeros.
- R6: With `ab_oe[h]`=0 and `ba_oe_n[h]`=1, neither bus is driven in half h.
- R7: With `ab_oe[h]`=1, `ba_oe_n[h]`=0 and both selects 1, both buses of half h are driven at once. The B bus gets the stored A-to-B word and the A bus gets the stored B-to-A word.
- R8: Loop-back store. When half h passes live A data onto the B bus, a `ba_clk[h]` edge stores that same A value into the B-to-A register.
- R9: Halves are independent. A capture edge or a control change in one half leaves the other half's registers and outputs unchanged.
- R10: When the live and stored values are equal, toggling a select leaves the driven output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all capture registers |
| ab_clk | input | NUM_HALVES | Per-half capture clock of the A-to-B register, rising edge |
| ba_clk | input | NUM_HALVES | Per-half capture clock of the B-to-A register, rising edge |
| ab_sel | input | NUM_HALVES | Per-half B-bus source: 0 live A data, 1 stored word |
| ba_sel | input | NUM_HALVES | Per-half A-bus source: 0 live B data, 1 stored word |
| ab_oe | input | NUM_HALVES | Per-half B-bus drive enable, active high |
| ba_oe_n | input | NUM_HALVES | Per-half A-bus drive enable, active low |
| a_in | input | HALF_W*NUM_HALVES | Resolved A bus value |
| b_in | input | HALF_W*NUM_HALVES | Resolved B bus value |
| a_out | output | HALF_W*NUM_HALVES | Data the block drives onto the A bus; zero when not driving |
| a_drv | output | NUM_HALVES | Per-half A-bus drive enable |
| b_out | output | HALF_W*NUM_HALVES | Data the block drives onto the B bus; zero when not driving |
| b_drv | output | NUM_HALVES | Per-half B-bus drive enable |

## Verification
Directed patterns come first:
- Captures made while the half is isolated are later exposed in the two-way stored mode. The A and B words differ, so a swapped or missed load shows up.
- A loop-back store places a value in the B-to-A register that could only have come from the A bus.
- A single-half capture shows whether the halves are kept apart.
- Live and stored words are set both different and equal. The different case separates the select polarities, and the equal case checks that toggling the select leaves the output unchanged.

Random enables, selects, external drive patterns and capture pulses then cover all four modes in both halves against a bench model. The bench resolves each bus with a bus-hold register, and every check also looks for cycles in which both the block and the external driver drive the same bus.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

    // Transfer mode of one half, decoded from its two output enables.
    typedef enum logic [1:0] {
        MODE_ISOLATE    = 2'b00,
        MODE_DRIVE_B    = 2'b01,
        MODE_DRIVE_A    = 2'b10,
        MODE_DRIVE_BOTH = 2'b11
    } xfer_mode_e;

    function automatic xfer_mode_e decode_mode(input logic oe_b_hi, input logic oe_a_lo);
        logic [1:0] code;
        code = {~oe_a_lo, oe_b_hi};
        return xfer_mode_e'(code);
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
`timescale 1ns/1ps
module xcvr_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             cap_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Loads on every rising capture edge; select and enable play no part.
    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_half.sv
`timescale 1ns/1ps
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             ab_clk,
    input  logic             ba_clk,
    input  logic             ab_sel,
    input  logic             ba_sel,
    input  logic             ab_oe,
    input  logic             ba_oe_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv
);

    logic [WIDTH-1:0] ab_word;
    logic [WIDTH-1:0] ba_word;
    logic [WIDTH-1:0] to_b;
    logic [WIDTH-1:0] to_a;
    xfer_mode_e       mode;

    xcvr_capture_reg #(.WIDTH(WIDTH)) u_ab_reg (
        .cap_clk (ab_clk),
        .rst_n   (rst_n),
        .d       (a_in),
        .q       (ab_word)
    );

    xcvr_capture_reg #(.WIDTH(WIDTH)) u_ba_reg (
        .cap_clk (ba_clk),
        .rst_n   (rst_n),
        .d       (b_in),
        .q       (ba_word)
    );

    // Source selection: a single two-input mux per direction, built only
    // from sampled bus inputs, so no path runs from an output to itself.
    always_comb begin
        to_b = ab_sel ? ab_word : a_in;
        to_a = ba_sel ? ba_word : b_in;
    end

    // Mode decode.
    always_comb begin
        mode = decode_mode(ab_oe, ba_oe_n);
    end

    // Output process per mode.
    always_comb begin
        a_out = '0;
        b_out = '0;
        a_drv = 1'b0;
        b_drv = 1'b0;
        unique case (mode)
            MODE_ISOLATE: begin
                a_drv = 1'b0;
                b_drv = 1'b0;
            end
            MODE_DRIVE_B: begin
                b_drv = 1'b1;
                b_out = to_b;
            end
            MODE_DRIVE_A: begin
                a_drv = 1'b1;
                a_out = to_a;
            end
            MODE_DRIVE_BOTH: begin
                a_drv = 1'b1;
                b_drv = 1'b1;
                a_out = to_a;
                b_out = to_b;
            end
        endcase
    end

endmodule

// File: rtl/regbus_xcvr.sv
`timescale 1ns/1ps
module regbus_xcvr #(
    parameter int HALF_W     = 8,
    parameter int NUM_HALVES = 2
) (
    input  logic                         rst_n,
    input  logic [NUM_HALVES-1:0]        ab_clk,
    input  logic [NUM_HALVES-1:0]        ba_clk,
    input  logic [NUM_HALVES-1:0]        ab_sel,
    input  logic [NUM_HALVES-1:0]        ba_sel,
    input  logic [NUM_HALVES-1:0]        ab_oe,
    input  logic [NUM_HALVES-1:0]        ba_oe_n,
    input  logic [HALF_W*NUM_HALVES-1:0] a_in,
    input  logic [HALF_W*NUM_HALVES-1:0] b_in,
    output logic [HALF_W*NUM_HALVES-1:0] a_out,
    output logic [NUM_HALVES-1:0]        a_drv,
    output logic [HALF_W*NUM_HALVES-1:0] b_out,
    output logic [NUM_HALVES-1:0]        b_drv
);

    localparam int BUS_W = HALF_W * NUM_HALVES;

    logic [BUS_W-1:0] a_out_w;
    logic [BUS_W-1:0] b_out_w;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        xcvr_half #(.WIDTH(HALF_W)) u_half (
            .rst_n   (rst_n),
            .ab_clk  (ab_clk[h]),
            .ba_clk  (ba_clk[h]),
            .ab_sel  (ab_sel[h]),
            .ba_sel  (ba_sel[h]),
            .ab_oe   (ab_oe[h]),
            .ba_oe_n (ba_oe_n[h]),
            .a_in    (a_in[h*HALF_W +: HALF_W]),
            .b_in    (b_in[h*HALF_W +: HALF_W]),
            .a_out   (a_out_w[h*HALF_W +: HALF_W]),
            .a_drv   (a_drv[h]),
            .b_out   (b_out_w[h*HALF_W +: HALF_W]),
            .b_drv   (b_drv[h])
        );
    end

    assign a_out = a_out_w;
    assign b_out = b_out_w;

endmodule

// File: rtl/regbus_xcvr_chk.sv
`timescale 1ns/1ps
module regbus_xcvr_chk #(
    parameter int HALF_W     = 8,
    parameter int NUM_HALVES = 2
) (
    input logic                         rst_n,
    input logic [NUM_HALVES-1:0]        ab_clk,
    input logic [NUM_HALVES-1:0]        ba_clk,
    input logic [NUM_HALVES-1:0]        ab_sel,
    input logic [NUM_HALVES-1:0]        ba_sel,
    input logic [NUM_HALVES-1:0]        ab_oe,
    input logic [NUM_HALVES-1:0]        ba_oe_n,
    input logic [HALF_W*NUM_HALVES-1:0] a_in,
    input logic [HALF_W*NUM_HALVES-1:0] b_in,
    input logic [HALF_W*NUM_HALVES-1:0] a_out,
    input logic [NUM_HALVES-1:0]        a_drv,
    input logic [HALF_W*NUM_HALVES-1:0] b_out,
    input logic [NUM_HALVES-1:0]        b_drv
);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
        // Set once a capture edge has occurred since reset, so $past only
        // refers to a sample taken after reset.
        logic ab_armed;
        logic ba_armed;

        always_ff @(posedge ab_clk[h] or negedge rst_n) begin
            if (!rst_n) ab_armed <= 1'b0;
            else        ab_armed <= 1'b1;
        end

        always_ff @(posedge ba_clk[h] or negedge rst_n) begin
            if (!rst_n) ba_armed <= 1'b0;
            else        ba_armed <= 1'b1;
        end

        AST_AB_LOAD: assert property ( // R2
            @(posedge ab_clk[h]) disable iff (!rst_n)
            (ab_armed && ab_oe[h] && ab_sel[h])
                |-> (b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W])));

        AST_BA_LOAD: assert property ( // R2
            @(posedge ba_clk[h]) disable iff (!rst_n)
            (ba_armed && !ba_oe_n[h] && ba_sel[h])
                |-> (a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W])));

        AST_ISOLATE: assert property ( // R6
            @(posedge ab_clk[h]) disable iff (!rst_n)
            (!ab_oe[h] && ba_oe_n[h]) |-> (!a_drv[h] && !b_drv[h]));

        AST_LIVE_TO_B: assert property ( // R4
            @(posedge ab_clk[h]) disable iff (!rst_n)
            (ab_oe[h] && !ab_sel[h])
                |-> (b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W]));

        AST_LIVE_TO_A: assert property ( // R4
            @(posedge ba_clk[h]) disable iff (!rst_n)
            (!ba_oe_n[h] && !ba_sel[h])
                |-> (a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W]));

        AST_IDLE_ZERO: assert property ( // R5
            @(posedge ab_clk[h]) disable iff (!rst_n)
            !ab_oe[h] |-> (!b_drv[h] && (b_out[h*HALF_W +: HALF_W] == '0)));

        AST_BOTH_DRIVEN: assert property ( // R7
            @(posedge ba_clk[h]) disable iff (!rst_n)
            (ab_oe[h] && !ba_oe_n[h] && ab_sel[h] && ba_sel[h]) |-> (a_drv[h] && b_drv[h]));
    end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_chk (
    .rst_n   (rst_n),
    .ab_clk  (ab_clk),
    .ba_clk  (ba_clk),
    .ab_sel  (ab_sel),
    .ba_sel  (ba_sel),
    .ab_oe   (ab_oe),
    .ba_oe_n (ba_oe_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .a_drv   (a_drv),
    .b_out   (b_out),
    .b_drv   (b_drv)
);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;

    localparam int HW = 8;
    localparam int NH = 2;
    localparam int BW = HW * NH;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [NH-1:0] ab_clk, ba_clk, ab_sel, ba_sel, ab_oe, ba_oe_n;
    logic [BW-1:0] a_in, b_in, a_out, b_out;
    logic [NH-1:0] a_drv, b_drv;

    logic [BW-1:0] ext_a, ext_b, a_hold, b_hold;
    logic [NH-1:0] ext_a_en, ext_b_en;
    logic [HW-1:0] m_ab [NH];
    logic [HW-1:0] m_ba [NH];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    regbus_xcvr #(.HALF_W(HW), .NUM_HALVES(NH)) u0 (
        .rst_n(rst_n), .ab_clk(ab_clk), .ba_clk(ba_clk),
        .ab_sel(ab_sel), .ba_sel(ba_sel), .ab_oe(ab_oe), .ba_oe_n(ba_oe_n),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_drv(a_drv),
        .b_out(b_out), .b_drv(b_drv)
    );

    // Bus resolution: external driver if on, otherwise the bus-hold value.
    always_comb begin
        for (int h = 0; h < NH; h++) begin
            a_in[h*HW +: HW] = ext_a_en[h] ? ext_a[h*HW +: HW] : a_hold[h*HW +: HW];
            b_in[h*HW +: HW] = ext_b_en[h] ? ext_b[h*HW +: HW] : b_hold[h*HW +: HW];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Refresh bus-hold values from whoever drives each bus.
    task automatic settle();
        for (int pass = 0; pass < 2; pass++) begin
            #1;
            for (int h = 0; h < NH; h++) begin
                if (!(ab_oe[h] && !ab_sel[h] && !ba_oe_n[h] && !ba_sel[h])) begin
                    if (a_drv[h])         a_hold[h*HW +: HW] = a_out[h*HW +: HW];
                    else if (ext_a_en[h]) a_hold[h*HW +: HW] = ext_a[h*HW +: HW];
                    if (b_drv[h])         b_hold[h*HW +: HW] = b_out[h*HW +: HW];
                    else if (ext_b_en[h]) b_hold[h*HW +: HW] = ext_b[h*HW +: HW];
                end
            end
        end
        #1;
    endtask

    // Compare every half against the bench model (R4, R5 rows; R1/R2/R3/R7 via state).
    task automatic check_all(input string tag);
        logic [HW-1:0] ea, eb;
        for (int h = 0; h < NH; h++) begin
            eb = ab_oe[h]   ? (ab_sel[h] ? m_ab[h] : a_in[h*HW +: HW]) : '0;
            ea = !ba_oe_n[h] ? (ba_sel[h] ? m_ba[h] : b_in[h*HW +: HW]) : '0;
            chk({tag, " R5 b_drv"}, 32'(b_drv[h]), 32'(ab_oe[h]));
            chk({tag, " R5 a_drv"}, 32'(a_drv[h]), 32'(!ba_oe_n[h]));
            chk({tag, " R4 b_out"}, 32'(b_out[h*HW +: HW]), 32'(eb));
            chk({tag, " R4 a_out"}, 32'(a_out[h*HW +: HW]), 32'(ea));
            chk({tag, " R6 contention"},
                32'((ext_a_en[h] && a_drv[h]) || (ext_b_en[h] && b_drv[h])), 32'd0);
        end
    endtask

    task automatic pulse(input logic [NH-1:0] pa, input logic [NH-1:0] pb);
        @(posedge clk);
        for (int h = 0; h < NH; h++) begin
            if (rst_n && pa[h]) m_ab[h] = a_in[h*HW +: HW];
            if (rst_n && pb[h]) m_ba[h] = b_in[h*HW +: HW];
        end
        ab_clk = pa;
        ba_clk = pb;
        @(negedge clk);
        ab_clk = '0;
        ba_clk = '0;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n    = 1'b0;
        ab_clk   = '0; ba_clk = '0;
        ab_sel   = '0; ba_sel = '0;
        ab_oe    = '0; ba_oe_n = '1;
        ext_a    = 16'hC3E1; ext_b = 16'h1E3C;
        ext_a_en = '1; ext_b_en = '1;
        a_hold   = '0; b_hold = '0;
        for (int h = 0; h < NH; h++) begin m_ab[h] = '0; m_ba[h] = '0; end

        // R6 / R1: isolated during reset; edges during reset load nothing.
        @(negedge clk); settle();
        check_all("R6 reset isolate");
        pulse('1, '1);
        @(negedge clk); rst_n = 1'b1; settle();

        // R1: stored words are zero after reset.
        ext_a_en = '0; ext_b_en = '0;
        ab_oe = '1; ab_sel = '1; ba_oe_n = '0; ba_sel = '1;
        settle();
        chk("R1 b_out zero", 32'(b_out), 32'd0);
        chk("R1 a_out zero", 32'(a_out), 32'd0);

        // R3: capture while isolated, with selects at mixed levels.
        @(negedge clk);
        ab_oe = '0; ba_oe_n = '1; ab_sel = 2'b01; ba_sel = 2'b10;
        ext_a = 16'h3C5A; ext_b = 16'hA5C3; ext_a_en = '1; ext_b_en = '1;
        settle();
        pulse('1, '1);

        // R7: two-way stored exchange.
        @(negedge clk);
        ext_a_en = '0; ext_b_en = '0;
        ab_oe = '1; ba_oe_n = '0; ab_sel = '1; ba_sel = '1;
        settle();
        chk("R3 R7 b_out stored A", 32'(b_out), 32'h3C5A);
        chk("R3 R7 a_out stored B", 32'(a_out), 32'hA5C3);
        chk("R7 both driven", 32'({a_drv, b_drv}), 32'hF);

        // R8: live A onto B, capture into B-to-A register.
        @(negedge clk);
        ab_oe = '1; ab_sel = '0; ba_oe_n = '1;
        ext_a = 16'h1122; ext_a_en = '1; ext_b_en = '0;
        settle();
        chk("R4 live A to B", 32'(b_out), 32'h1122);
        pulse('0, '1);
        @(negedge clk);
        ab_oe = '0; ba_oe_n = '0; ba_sel = '1; ext_a_en = '0; ext_b_en = '1;
        ext_b = 16'hFFFF;
        settle();
        chk("R8 loop-back stored", 32'(a_out), 32'h1122);

        // R9: capture in half 0 only.
        @(negedge clk);
        ab_oe = '0; ba_oe_n = '1; ext_a = 16'h7E96; ext_a_en = '1;
        settle();
        pulse(2'b01, 2'b00);
        @(negedge clk);
        ab_oe = '1; ab_sel = '1; ext_b_en = '0;
        settle();
        chk("R9 half1 unchanged", 32'(b_out[15:8]), 32'h3C);
        chk("R2 half0 loaded", 32'(b_out[7:0]), 32'h96);

        // R10: equal live and stored, toggle select.
        @(negedge clk); ext_a = 16'h3C96; ab_sel = '0; settle();
        chk("R10 live equal", 32'(b_out), 32'h3C96);
        @(negedge clk); ab_sel = '1; settle();
        chk("R10 stored equal", 32'(b_out), 32'h3C96);
        @(negedge clk); ext_a = 16'h0F0F; settle();
        chk("R4 stored differs", 32'(b_out), 32'h3C96);
        @(negedge clk); ab_sel = '0; settle();
        chk("R4 live differs", 32'(b_out), 32'h0F0F);

        // Random mix over all modes in both halves.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            ab_oe   = NH'($urandom);
            ba_oe_n = NH'($urandom);
            ab_sel  = NH'($urandom);
            ba_sel  = NH'($urandom);
            ext_a   = BW'($urandom);
            ext_b   = BW'($urandom);
            ext_a_en = NH'($urandom) & ba_oe_n;
            ext_b_en = NH'($urandom) & ~ab_oe;
            settle();
            check_all("R4 R5 random");
            pulse(NH'($urandom), NH'($urandom));
            check_all("R2 R3 random after capture");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule